// File: doc/BRIEF.md
# Payload Word-to-Byte Packer

This block sits between 32-bit word FIFOs and a byte-serial bus engine and handles the payload of one transfer at a time. A transfer is started with a direction and a byte length of up to 12 bits. For a write it pulls words from the outgoing word stream and hands bytes one at a time to the bit engine. For a read it takes bytes from the bit engine and packs them into words for the incoming word stream.

The two directions deliberately use opposite lane orders. Outgoing bytes are taken from the least significant lane of each word upward. Incoming bytes fill a word from the most significant lane downward. Each transfer starts on a fresh word in both directions. An outgoing final word that is only partly used has its spare lanes dropped. An incoming final word that is only partly filled is pushed with its empty lanes cleared. A read can be cut short by the far side, and the packer then reports how many bytes really arrived. All stream interfaces are valid/ready.

Top module: `payload_packer`

## Requirements
- R1: A start request is accepted only while `busy` is low. A request with a non-zero length raises `busy` on the next cycle. A start request raised while `busy` is high has no effect: no words or bytes move for it, and the count reported at the next `done` belongs to the transfer already running.
- R2: On a write, payload byte k is bits [8*(k mod 4)+7 : 8*(k mod 4)] of the (k div 4)-th word taken in that transfer. Byte lane 0 goes first. For example, word 0x78563412 goes out as 0x12, 0x34, 0x56, 0x78.
- R3: A write of n bytes takes exactly ceil(n/4) words and emits exactly n bytes. The unused upper lanes of a partial final word are discarded. The next transfer starts with lane 0 of a newly taken word.
- R4: On a read, the first byte of each word lands in bits [31:24], the second in [23:16], the third in [15:8] and the fourth in [7:0].
- R5: A read that ends part way through a word pushes that word with its unfilled lower lanes equal to zero. Exactly ceil(m/4) words are pushed for m received bytes, and no word is ever pushed without data in it.
- R6: A transfer of length 0 takes no word and pushes no word. It raises `done` in the cycle after the start is accepted, with `xfer_count` equal to 0.
- R7: `done` is high for exactly one cycle. For a write, that cycle is the one after the final byte handshake. For a read, it is the cycle after the final word handshake. While `done` is high, `xfer_count` holds the number of bytes transferred.
- R8: On a read, a byte received with `rxb_last` high ends the transfer. The partial word is flushed, and `xfer_count` reports the number of bytes actually received.
- R9: While `txb_valid` is high and `txb_ready` is low, `txb_valid` and `txb_data` stay unchanged. The same holds for `sdi_valid`/`sdi_word` while `sdi_ready` is low.
- R10: After reset, `busy`, `done`, `sdo_ready`, `txb_valid`, `rxb_ready` and `sdi_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a transfer |
| start_rx | input | 1 | Direction of the requested transfer: 1 for read, 0 for write |
| start_len | input | 12 | Payload length in bytes |
| sdo_word | input | 32 | Outgoing payload word |
| sdo_valid | input | 1 | Outgoing word available |
| sdo_ready | output | 1 | Packer takes the outgoing word |
| txb_data | output | 8 | Byte to the bit engine |
| txb_valid | output | 1 | Byte to the bit engine is valid |
| txb_ready | input | 1 | Bit engine takes the byte |
| rxb_data | input | 8 | Byte from the bit engine |
| rxb_valid | input | 1 | Byte from the bit engine is valid |
| rxb_last | input | 1 | Far side ended the read with this byte |
| rxb_ready | output | 1 | Packer takes the received byte |
| sdi_word | output | 32 | Packed incoming word |
| sdi_valid | output | 1 | Packed word is valid |
| sdi_ready | input | 1 | Consumer takes the packed word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| xfer_count | output | 12 | Bytes transferred, valid with done |

## Verification
Writes are run with lengths of 1, 3, 4, 5 and 12. These separate whole-word payloads from payloads that end part way through a word. Back-to-back writes show that a new transfer does not pick up lanes left over from the previous word. Reads of 1, 4, 5 and 6 bytes, and reads cut short after 1, 4 and 6 bytes, separate a full final word from a flushed partial one and a natural end from an early one. Zero-length transfers in both directions, a start raised during a busy write, and stalls on both the byte and word sides cover the idle, ignored-request and hold cases.

// File: rtl/payload_pack_pkg.sv
package payload_pack_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_FETCH,
        TX_SEND
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_COLLECT,
        RX_PUSH
    } rx_state_e;

    // Number of byte lanes in a word of the given width.
    function automatic int lanes_in(input int word_w);
        return word_w / BYTE_W;
    endfunction

endpackage

// File: rtl/pk_tx_unpack.sv
module pk_tx_unpack
    import payload_pack_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [LEN_W-1:0]  go_len,
    input  logic [WORD_W-1:0] sdo_word,
    input  logic              sdo_valid,
    output logic              sdo_ready,
    output logic [BYTE_W-1:0] txb_data,
    output logic              txb_valid,
    input  logic              txb_ready,
    output logic              busy,
    output logic              done
);
    localparam int LANES  = lanes_in(WORD_W);
    localparam int LANE_W = $clog2(LANES);

    tx_state_e          state_q;
    logic [WORD_W-1:0]  word_q;
    logic [LANE_W-1:0]  lane_q;
    logic [LEN_W-1:0]   remain_q;
    logic               done_q;
    logic [BYTE_W-1:0]  lane_byte [LANES];

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        assign lane_byte[gi] = word_q[gi*BYTE_W +: BYTE_W];
    end

    assign txb_data  = lane_byte[lane_q];
    assign txb_valid = (state_q == TX_SEND);
    assign sdo_ready = (state_q == TX_FETCH);
    assign busy      = (state_q != TX_IDLE);
    assign done      = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= TX_IDLE;
            word_q   <= '0;
            lane_q   <= '0;
            remain_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                TX_IDLE: begin
                    if (go) begin
                        remain_q <= go_len;
                        state_q  <= TX_FETCH;
                    end
                end
                TX_FETCH: begin
                    if (sdo_valid) begin
                        word_q  <= sdo_word;
                        lane_q  <= '0;
                        state_q <= TX_SEND;
                    end
                end
                TX_SEND: begin
                    if (txb_ready) begin
                        remain_q <= remain_q - LEN_W'(1);
                        if (remain_q == LEN_W'(1)) begin
                            state_q <= TX_IDLE;
                            done_q  <= 1'b1;
                        end else if (lane_q == LANE_W'(LANES - 1)) begin
                            state_q <= TX_FETCH;
                        end else begin
                            lane_q <= lane_q + LANE_W'(1);
                        end
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    // R9: a stalled byte is held
    p_txb_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (txb_valid && !txb_ready) |=> (txb_valid && $stable(txb_data)));

    // R3: never emitting with nothing left to send
    p_remain_live_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q != TX_IDLE) |-> (remain_q != '0));

    // R3: a word is only taken when the lane pointer restarts
    p_fetch_restart_r3: assert property (@(posedge clk) disable iff (rst)
        (sdo_valid && sdo_ready) |=> (txb_valid && lane_q == '0));

endmodule

// File: rtl/pk_rx_pack.sv
module pk_rx_pack
    import payload_pack_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [LEN_W-1:0]  go_len,
    input  logic [BYTE_W-1:0] rxb_data,
    input  logic              rxb_valid,
    input  logic              rxb_last,
    output logic              rxb_ready,
    output logic [WORD_W-1:0] sdi_word,
    output logic              sdi_valid,
    input  logic              sdi_ready,
    output logic              busy,
    output logic              done,
    output logic [LEN_W-1:0]  got_count
);
    localparam int LANES  = lanes_in(WORD_W);
    localparam int FILL_W = $clog2(LANES) + 1;

    rx_state_e          state_q;
    logic [WORD_W-1:0]  word_q;
    logic [WORD_W-1:0]  word_nx;
    logic [FILL_W-1:0]  fill_q;
    logic [LEN_W-1:0]   got_q;
    logic [LEN_W-1:0]   target_q;
    logic [LEN_W-1:0]   got_nx;
    logic               final_q;
    logic               done_q;
    logic               end_byte;

    assign rxb_ready = (state_q == RX_COLLECT);
    assign sdi_valid = (state_q == RX_PUSH);
    assign sdi_word  = word_q;
    assign busy      = (state_q != RX_IDLE);
    assign done      = done_q;
    assign got_count = got_q;
    assign got_nx    = got_q + LEN_W'(1);
    assign end_byte  = (got_nx == target_q) || rxb_last;

    // Incoming bytes fill from the top lane down.
    always_comb begin
        word_nx = word_q;
        for (int i = 0; i < LANES; i++) begin
            if (FILL_W'(LANES - 1 - i) == fill_q) begin
                word_nx[i*BYTE_W +: BYTE_W] = rxb_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= RX_IDLE;
            word_q   <= '0;
            fill_q   <= '0;
            got_q    <= '0;
            target_q <= '0;
            final_q  <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    if (go) begin
                        word_q   <= '0;
                        fill_q   <= '0;
                        got_q    <= '0;
                        target_q <= go_len;
                        final_q  <= 1'b0;
                        state_q  <= RX_COLLECT;
                    end
                end
                RX_COLLECT: begin
                    if (rxb_valid) begin
                        word_q <= word_nx;
                        fill_q <= fill_q + FILL_W'(1);
                        got_q  <= got_nx;
                        if (end_byte || fill_q == FILL_W'(LANES - 1)) begin
                            final_q <= end_byte;
                            state_q <= RX_PUSH;
                        end
                    end
                end
                RX_PUSH: begin
                    if (sdi_ready) begin
                        if (final_q) begin
                            state_q <= RX_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            word_q  <= '0;
                            fill_q  <= '0;
                            state_q <= RX_COLLECT;
                        end
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    // R9: a stalled word is held
    p_sdi_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (sdi_valid && !sdi_ready) |=> (sdi_valid && $stable(sdi_word)));

    // R5: no word is pushed without data
    p_no_empty_push_r5: assert property (@(posedge clk) disable iff (rst)
        sdi_valid |-> (fill_q != '0));

    // R8: never more bytes than requested
    p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (got_q <= target_q));

endmodule

// File: rtl/payload_packer.sv
module payload_packer
    import payload_pack_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_rx,
    input  logic [LEN_W-1:0]  start_len,
    input  logic [WORD_W-1:0] sdo_word,
    input  logic              sdo_valid,
    output logic              sdo_ready,
    output logic [BYTE_W-1:0] txb_data,
    output logic              txb_valid,
    input  logic              txb_ready,
    input  logic [BYTE_W-1:0] rxb_data,
    input  logic              rxb_valid,
    input  logic              rxb_last,
    output logic              rxb_ready,
    output logic [WORD_W-1:0] sdi_word,
    output logic              sdi_valid,
    input  logic              sdi_ready,
    output logic              busy,
    output logic              done,
    output logic [LEN_W-1:0]  xfer_count
);
    logic              accept;
    logic              nonzero;
    logic              go_tx;
    logic              go_rx;
    logic              tx_busy;
    logic              rx_busy;
    logic              tx_done;
    logic              rx_done;
    logic              zero_q;
    logic              dir_rx_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  rx_got;

    assign busy    = tx_busy | rx_busy;
    assign accept  = start && !busy;
    assign nonzero = (start_len != '0);
    assign go_tx   = accept && nonzero && !start_rx;
    assign go_rx   = accept && nonzero && start_rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_q   <= 1'b0;
            dir_rx_q <= 1'b0;
            len_q    <= '0;
        end else begin
            zero_q <= accept && !nonzero;
            if (accept) begin
                len_q    <= start_len;
                dir_rx_q <= start_rx && nonzero;
            end
        end
    end

    assign done       = tx_done | rx_done | zero_q;
    assign xfer_count = dir_rx_q ? rx_got : len_q;

    pk_tx_unpack #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .go        (go_tx),
        .go_len    (start_len),
        .sdo_word  (sdo_word),
        .sdo_valid (sdo_valid),
        .sdo_ready (sdo_ready),
        .txb_data  (txb_data),
        .txb_valid (txb_valid),
        .txb_ready (txb_ready),
        .busy      (tx_busy),
        .done      (tx_done)
    );

    pk_rx_pack #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .go        (go_rx),
        .go_len    (start_len),
        .rxb_data  (rxb_data),
        .rxb_valid (rxb_valid),
        .rxb_last  (rxb_last),
        .rxb_ready (rxb_ready),
        .sdi_word  (sdi_word),
        .sdi_valid (sdi_valid),
        .sdi_ready (sdi_ready),
        .busy      (rx_busy),
        .done      (rx_done),
        .got_count (rx_got)
    );

    // R7: completion is a single-cycle pulse
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1: an accepted non-empty request makes the block busy
    p_accept_busy_r1: assert property (@(posedge clk) disable iff (rst)
        (accept && nonzero) |=> busy);

    // R1: the two directions never run together
    p_dir_excl_r1: assert property (@(posedge clk) disable iff (rst)
        !(tx_busy && rx_busy));

    // R6: an empty transfer completes at once and moves nothing
    p_zero_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && !nonzero) |=> (done && !busy && xfer_count == '0));

endmodule

// File: tb/tb_payload_packer.sv
module tb_payload_packer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        start_rx = 1'b0;
    logic [11:0] start_len = '0;
    logic [31:0] sdo_word = '0;
    logic        sdo_valid = 1'b0;
    logic        sdo_ready;
    logic [7:0]  txb_data;
    logic        txb_valid;
    logic        txb_ready = 1'b0;
    logic [7:0]  rxb_data = '0;
    logic        rxb_valid = 1'b0;
    logic        rxb_last = 1'b0;
    logic        rxb_ready;
    logic [31:0] sdi_word;
    logic        sdi_valid;
    logic        sdi_ready = 1'b0;
    logic        busy;
    logic        done;
    logic [11:0] xfer_count;

    always #4 clk = ~clk;

    payload_packer dut (
        .clk(clk), .rst(rst), .start(start), .start_rx(start_rx), .start_len(start_len),
        .sdo_word(sdo_word), .sdo_valid(sdo_valid), .sdo_ready(sdo_ready),
        .txb_data(txb_data), .txb_valid(txb_valid), .txb_ready(txb_ready),
        .rxb_data(rxb_data), .rxb_valid(rxb_valid), .rxb_last(rxb_last), .rxb_ready(rxb_ready),
        .sdi_word(sdi_word), .sdi_valid(sdi_valid), .sdi_ready(sdi_ready),
        .busy(busy), .done(done), .xfer_count(xfer_count)
    );

    logic [31:0] sdo_src [$];
    logic [8:0]  rx_src  [$];
    logic [7:0]  exp_b   [$];
    logic [31:0] exp_w   [$];

    int checks = 0;
    int fails = 0;
    int done_cnt = 0;
    int cyc = 0;
    bit stall = 0;
    bit sdo_hs = 0, rx_hs = 0, tx_hold = 0, sdi_hold = 0, want_done = 0;
    logic [7:0]  tx_prev = '0;
    logic [31:0] sdi_prev = '0;
    logic [11:0] last_count = '0;

    function automatic void check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endfunction

    function automatic logic [31:0] mkword(int seed, int w);
        if (seed == 0) return (w == 0) ? 32'h78563412 : 32'h000000FE;
        return (32'(seed) * 32'h1F2E3D4C + 32'(w) * 32'h01030507) ^ 32'hA5A55A5A;
    endfunction

    // Source drivers: update inputs just after each rising edge
    always @(posedge clk) begin
        #1;
        cyc++;
        if (sdo_hs) void'(sdo_src.pop_front());
        if (rx_hs)  void'(rx_src.pop_front());
        sdo_valid = (sdo_src.size() > 0);
        sdo_word  = (sdo_src.size() > 0) ? sdo_src[0] : 32'h0;
        rxb_valid = (rx_src.size() > 0);
        rxb_data  = (rx_src.size() > 0) ? rx_src[0][7:0] : 8'h0;
        rxb_last  = (rx_src.size() > 0) ? rx_src[0][8] : 1'b0;
        txb_ready = stall ? (cyc % 3 != 0) : 1'b1;
        sdi_ready = stall ? (cyc % 4 != 1) : 1'b1;
    end

    // Monitor / scoreboard: sample between edges
    always @(negedge clk) begin
        if (rst) begin
            sdo_hs = 0; rx_hs = 0; tx_hold = 0; sdi_hold = 0; want_done = 0;
        end else begin
            if (want_done) begin
                check(done === 1'b1, "R7", "done after final handshake", 32'(done), 1);
                want_done = 0;
            end
            if (tx_hold)
                check(txb_valid && txb_data == tx_prev, "R9", "stalled byte held", 32'(txb_data), 32'(tx_prev));
            if (sdi_hold)
                check(sdi_valid && sdi_word == sdi_prev, "R9", "stalled word held", sdi_word, sdi_prev);
            if (done) begin
                done_cnt++;
                last_count = xfer_count;
            end
            sdo_hs = sdo_valid && sdo_ready;
            rx_hs  = rxb_valid && rxb_ready;
            if (txb_valid && txb_ready) begin
                if (exp_b.size() == 0) check(0, "R3", "byte beyond payload", 32'(txb_data), 0);
                else begin
                    logic [7:0] e;
                    e = exp_b.pop_front();
                    check(txb_data == e, "R2", "tx byte order", 32'(txb_data), 32'(e));
                    if (exp_b.size() == 0) want_done = 1;
                end
            end
            if (sdi_valid && sdi_ready) begin
                if (exp_w.size() == 0) check(0, "R5", "unexpected word pushed", sdi_word, 0);
                else begin
                    logic [31:0] e;
                    e = exp_w.pop_front();
                    check(sdi_word == e, "R4", "rx word packing", sdi_word, e);
                    if (exp_w.size() == 0) want_done = 1;
                end
            end
            tx_hold  = txb_valid && !txb_ready;
            tx_prev  = txb_data;
            sdi_hold = sdi_valid && !sdi_ready;
            sdi_prev = sdi_word;
        end
    end

    task automatic start_xfer(bit rx, int n);
        @(posedge clk); #2;
        start = 1'b1; start_rx = rx; start_len = 12'(n);
        @(posedge clk); #2;
        start = 1'b0;
    endtask

    task automatic wait_done(string req);
        int base = done_cnt;
        int t = 0;
        while (done_cnt == base && t < 2000) begin
            @(negedge clk);
            t++;
        end
        check(done_cnt > base, req, "done seen", 32'(done_cnt - base), 1);
    endtask

    task automatic run_tx(int n, int seed, bit poke);
        for (int w = 0; w < (n + 3) / 4; w++) sdo_src.push_back(mkword(seed, w));
        for (int i = 0; i < n; i++) begin
            logic [31:0] wd;
            wd = mkword(seed, i / 4);
            exp_b.push_back(wd[8*(i%4) +: 8]);
        end
        start_xfer(1'b0, n);
        if (poke) begin
            repeat (3) @(posedge clk);
            #2;
            check(busy === 1'b1, "R1", "busy during write", 32'(busy), 1);
            start = 1'b1; start_rx = 1'b1; start_len = 12'd3;
            @(posedge clk); #2;
            start = 1'b0;
        end
        wait_done("R7");
        check(last_count == 12'(n), "R7", "write count", 32'(last_count), 32'(n));
        check(exp_b.size() == 0, "R2", "all bytes sent", 32'(exp_b.size()), 0);
        check(sdo_src.size() == 0, "R3", "words taken", 32'(sdo_src.size()), 0);
        repeat (2) @(posedge clk);
    endtask

    task automatic run_rx(int n, int early, int seed);
        int m;
        logic [31:0] ws [4];
        m = (early > 0 && early < n) ? early : n;
        for (int w = 0; w < 4; w++) ws[w] = '0;
        for (int k = 0; k < m; k++) begin
            logic [7:0] b;
            b = 8'(seed * 7 + k * 13 + 1);
            rx_src.push_back({(early > 0 && k == m - 1), b});
            ws[k/4][31 - 8*(k%4) -: 8] = b;
        end
        for (int w = 0; w < (m + 3) / 4; w++) exp_w.push_back(ws[w]);
        start_xfer(1'b1, n);
        wait_done("R7");
        check(last_count == 12'(m), early > 0 ? "R8" : "R7", "read count", 32'(last_count), 32'(m));
        check(exp_w.size() == 0, "R5", "all words pushed", 32'(exp_w.size()), 0);
        check(rx_src.size() == 0, "R8", "bytes taken", 32'(rx_src.size()), 0);
        repeat (2) @(posedge clk);
    endtask

    task automatic run_zero(bit rx);
        if (rx) rx_src.push_back(9'h0AB);
        else    sdo_src.push_back(32'hDEADBEEF);
        start_xfer(rx, 0);
        check(done === 1'b1, "R6", "zero length done", 32'(done), 1);
        check(xfer_count == 12'd0, "R6", "zero length count", 32'(xfer_count), 0);
        repeat (5) @(posedge clk);
        #2;
        if (rx) check(rx_src.size() == 1, "R6", "no byte taken", 32'(rx_src.size()), 1);
        else    check(sdo_src.size() == 1, "R6", "no word taken", 32'(sdo_src.size()), 1);
        check(busy === 1'b0, "R6", "idle after zero length", 32'(busy), 0);
        rx_src.delete();
        sdo_src.delete();
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2;
        check(!busy && !done && !sdo_ready && !txb_valid && !rxb_ready && !sdi_valid,
              "R10", "reset outputs", {26'b0, busy, done, sdo_ready, txb_valid, rxb_ready, sdi_valid}, 0);
        rst = 1'b0;
        repeat (2) @(posedge clk);

        run_tx(5, 0, 0);      // R2 R3: 12 34 56 78 FE, spare lanes dropped
        run_tx(3, 3, 0);      // R3: fresh word on next transfer
        run_tx(4, 1, 0);
        run_tx(1, 4, 0);
        stall = 1;
        run_tx(12, 5, 1);     // R1 ignored start, R9 stalls
        run_tx(7, 6, 0);
        run_rx(5, 0, 2);      // R4 R5 partial flush
        stall = 0;
        run_rx(4, 0, 1);
        run_rx(6, 0, 3);
        run_rx(1, 0, 4);
        run_rx(9, 6, 5);      // R8 early end mid-word
        run_rx(8, 4, 6);      // R8 early end on word boundary
        run_rx(3, 1, 7);
        run_zero(0);          // R6
        run_zero(1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule